// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is one DMA channel that copies words from a source region to a target region, driven by descriptors kept in memory. Each descriptor occupies four consecutive words: a link to the next descriptor, the source address, the target address, and a command word whose low bits hold the byte count. The channel reads a descriptor, moves its words one read and one write at a time over a single word-wide memory master port, then follows the link. It stops when the descriptor just finished carries a stop marker.

Software places the first descriptor's address in the link register and then sets the run bit. Clearing the run bit asks the channel to pause. The channel finishes the word move it has begun and then reports that it has stopped. Only after that report may software edit the descriptor list. Setting run again resumes a paused copy where it left off. When the current descriptor is finished, setting run fetches the descriptor held in the link register.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset `stopped_o` is 1, `run_o` is 0 and `mem_req` is 0.
- R2: Writing 1 to the run bit while stopped drives `stopped_o` low on the following cycle. The channel then reads the four descriptor words at link, link+4, link+8 and link+12, in that order.
- R3: A request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_gnt` is seen. Each grant completes exactly one access, and `mem_req` is low in the cycle after the grant.
- R4: The byte count is bits 12:0 of the command word, and its low two bits are ignored. For a count L, the channel moves L/4 words (integer division). Each word is read from the source and then written unchanged to the target, and both addresses advance by 4 per word. Every address driven on `mem_addr` has bits 1:0 equal to 0.
- R5: Bit 0 of the link word is the stop marker. When it is set, the channel stops once the descriptor's last word has been written. It then shows `stopped_o` = 1 and `run_o` = 0 and issues no further request.
- R6: When the stop marker is clear, the channel next fetches the descriptor at the link word with bits 3:0 cleared.
- R7: A descriptor whose word count is zero causes no data access. With the stop marker set, the channel stops right after the fetch. With it clear, the channel goes directly to the linked descriptor.
- R8: Writing 0 to the run bit during a copy lets the word move in progress finish with its write. After that the channel issues no further request, and `stopped_o` rises.
- R9: Setting run after a pause with words remaining continues at the preserved source and target addresses and remaining count, without fetching a descriptor again.
- R10: After a stop at the end of a descriptor, a new link address followed by setting run starts a fetch at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_next_we | input | 1 | Write strobe for the link register (taken only while stopped) |
| cfg_next_wdata | input | W | New link address (bits 3:0 dropped) |
| cfg_run_we | input | 1 | Write strobe for the run bit |
| cfg_run_wdata | input | 1 | Value written to the run bit |
| run_o | output | 1 | Current run bit |
| stopped_o | output | 1 | High while the channel is halted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | W | Byte address of the access |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with `mem_gnt` |
| mem_gnt | input | 1 | Grant; completes the pending access |

## Verification
If a working register were corrupted, the error would appear on `mem_addr` at the next request. A wrong link or a lost stop marker shows as a fetch at an unexpected address, or as a request after the channel should have halted. A wrong count shows as too many or too few writes before `stopped_o` rises. A wrong pause state shows once run is set again, because the first access is not a read at the preserved source address. Memory access logs and target contents are compared against values worked out from the descriptors. Each run is given as many latency settings as it needs, so that ordering errors surface within one word move.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int DESC_WORDS = 4;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dma_state_e;
endpackage

// File: rtl/dma_mem_port.sv
module dma_mem_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic         issue_we,
  input  logic [W-1:0] issue_addr,
  input  logic [W-1:0] issue_wdata,
  input  logic         mem_gnt,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         busy,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (issue) begin
      mem_req   <= 1'b1;
      mem_we    <= issue_we;
      mem_addr  <= issue_addr;
      mem_wdata <= issue_wdata;
    end else if (mem_req && mem_gnt) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end
  end

  assign busy = mem_req;
  assign done = mem_req && mem_gnt;
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
  parameter int W  = 32,
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_src,
  input  logic          ld_dst,
  input  logic          ld_len,
  input  logic          advance,
  input  logic [W-1:0]  addr_in,
  input  logic [LW-1:0] len_in,
  output logic [W-1:0]  src,
  output logic [W-1:0]  dst,
  output logic          len_zero,
  output logic          len_last
);
  localparam logic [W-1:0]  ADDR_MASK = ~W'(3);
  localparam logic [LW-1:0] LEN_MASK  = ~LW'(3);
  localparam logic [W-1:0]  ADDR_STEP = W'(4);
  localparam logic [LW-1:0] LEN_STEP  = LW'(4);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src   <= '0;
      dst   <= '0;
      len_q <= '0;
    end else begin
      if (ld_src) src <= addr_in & ADDR_MASK;
      if (ld_dst) dst <= addr_in & ADDR_MASK;
      if (ld_len) len_q <= len_in & LEN_MASK;
      if (advance) begin
        src   <= src + ADDR_STEP;
        dst   <= dst + ADDR_STEP;
        len_q <= len_q - LEN_STEP;
      end
    end
  end

  assign len_zero = (len_q == '0);
  assign len_last = (len_q == LEN_STEP);
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_next_we,
  input  logic [W-1:0] cfg_next_wdata,
  input  logic         cfg_run_we,
  input  logic         cfg_run_wdata,
  output logic         run_o,
  output logic         stopped_o,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_gnt
);
  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [W-1:0]  LINK_MASK = ~W'(15);
  localparam logic [IW-1:0] LAST_IDX  = IW'(DESC_WORDS - 1);

  dma_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  next_q, base_q, data_q;
  logic          stop_q, run_q, stopped_q;

  logic          issue, issue_we, busy, done;
  logic [W-1:0]  issue_addr;
  logic [W-1:0]  src, dst;
  logic          len_zero, len_last;
  logic          ld_src, ld_dst, ld_len, advance;
  logic          end_idle, fetch_last, cmd_zero;

  assign end_idle   = stop_q || !run_q;
  assign fetch_last = (state_q == ST_FETCH) && done && (idx_q == LAST_IDX);
  assign cmd_zero   = (mem_rdata[LW-1:2] == '0);
  assign ld_src     = (state_q == ST_FETCH) && done && (idx_q == IW'(1));
  assign ld_dst     = (state_q == ST_FETCH) && done && (idx_q == IW'(2));
  assign ld_len     = fetch_last;
  assign advance    = (state_q == ST_WRITE) && done;

  always_comb begin
    issue      = 1'b0;
    issue_we   = 1'b0;
    issue_addr = '0;
    unique case (state_q)
      ST_FETCH: if (!busy) begin
        issue      = 1'b1;
        issue_addr = base_q + {{(W-IW-2){1'b0}}, idx_q, 2'b00};
      end
      ST_READ: if (!busy && run_q) begin
        issue      = 1'b1;
        issue_addr = src;
      end
      ST_WRITE: if (!busy) begin
        issue      = 1'b1;
        issue_we   = 1'b1;
        issue_addr = dst;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      next_q    <= '0;
      base_q    <= '0;
      data_q    <= '0;
      stop_q    <= 1'b0;
      run_q     <= 1'b0;
      stopped_q <= 1'b1;
    end else begin
      if (cfg_run_we) run_q <= cfg_run_wdata;
      if (cfg_next_we && state_q == ST_IDLE) next_q <= cfg_next_wdata & LINK_MASK;
      unique case (state_q)
        ST_IDLE: if (cfg_run_we && cfg_run_wdata) begin
          stopped_q <= 1'b0;
          if (!len_zero) begin
            state_q <= ST_READ;
          end else begin
            state_q <= ST_FETCH;
            base_q  <= next_q;
            idx_q   <= '0;
          end
        end
        ST_FETCH: if (done) begin
          idx_q <= idx_q + IW'(1);
          if (idx_q == '0) begin
            next_q <= mem_rdata & LINK_MASK;
            stop_q <= mem_rdata[0];
          end
          if (fetch_last) begin
            if (!cmd_zero) begin
              if (run_q) begin
                state_q <= ST_READ;
              end else begin
                state_q   <= ST_IDLE;
                stopped_q <= 1'b1;
              end
            end else if (end_idle) begin
              state_q   <= ST_IDLE;
              stopped_q <= 1'b1;
              if (stop_q) run_q <= 1'b0;
            end else begin
              state_q <= ST_FETCH;
              base_q  <= next_q;
              idx_q   <= '0;
            end
          end
        end
        ST_READ: begin
          if (!busy && !run_q) begin
            state_q   <= ST_IDLE;
            stopped_q <= 1'b1;
          end else if (done) begin
            data_q  <= mem_rdata;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: if (done) begin
          if (!len_last) begin
            state_q <= ST_READ;
          end else if (end_idle) begin
            state_q   <= ST_IDLE;
            stopped_q <= 1'b1;
            if (stop_q) run_q <= 1'b0;
          end else begin
            state_q <= ST_FETCH;
            base_q  <= next_q;
            idx_q   <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dma_mem_port #(.W(W)) u_port (
    .clk(clk), .rst(rst), .issue(issue), .issue_we(issue_we),
    .issue_addr(issue_addr), .issue_wdata(data_q), .mem_gnt(mem_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  dma_xfer_regs #(.W(W), .LW(LW)) u_xfer (
    .clk(clk), .rst(rst), .ld_src(ld_src), .ld_dst(ld_dst), .ld_len(ld_len),
    .advance(advance), .addr_in(mem_rdata), .len_in(mem_rdata[LW-1:0]),
    .src(src), .dst(dst), .len_zero(len_zero), .len_last(len_last)
  );

  assign run_o     = run_q;
  assign stopped_o = stopped_q;
endmodule

// File: rtl/dma_chain_checker.sv
module dma_chain_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_run_we,
  input logic         cfg_run_wdata,
  input logic         stopped_o,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_gnt
);
  // R3: pending request is held steady until granted
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3: one access per grant
  a_r3_one_per_grant: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_gnt |=> !mem_req);

  // R4: word-aligned addresses only
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R2: stop-state clears the cycle after run is set
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    stopped_o && cfg_run_we && cfg_run_wdata |=> !stopped_o);

  // R5: a halted channel issues nothing
  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    stopped_o |-> !mem_req);
endmodule

bind dma_chain_channel dma_chain_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cfg_run_we(cfg_run_we), .cfg_run_wdata(cfg_run_wdata),
  .stopped_o(stopped_o), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
);

// File: tb/tb_dma_chain_channel.sv
`timescale 1ns/1ps
module tb_dma_chain_channel;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_next_we = 1'b0, cfg_run_we = 1'b0, cfg_run_wdata = 1'b0;
  logic [W-1:0] cfg_next_wdata = '0;
  logic run_o, stopped_o, mem_req, mem_we;
  logic [W-1:0] mem_addr, mem_wdata;
  logic [W-1:0] mem_rdata = '0;
  logic mem_gnt = 1'b0;

  always #2.5 clk = ~clk;

  dma_chain_channel #(.W(W), .LW(13)) dut (
    .clk(clk), .rst(rst), .cfg_next_we(cfg_next_we), .cfg_next_wdata(cfg_next_wdata),
    .cfg_run_we(cfg_run_we), .cfg_run_wdata(cfg_run_wdata), .run_o(run_o),
    .stopped_o(stopped_o), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
  );

  logic [31:0] mem [0:255];
  logic [31:0] log_addr [0:127];
  logic        log_we   [0:127];
  int n_log = 0, lat = 0, wcnt = 0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (mem_req && !mem_gnt) begin
      if (wcnt >= lat) begin
        mem_gnt   = 1'b1;
        mem_rdata = mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        if (n_log < 128) begin
          log_addr[n_log] = mem_addr;
          log_we[n_log]   = mem_we;
        end
        n_log++;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else begin
      mem_gnt = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_all();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic put_desc(input int a, input logic [31:0] link, src, dst, cmd);
    mem[a/4] = link; mem[a/4+1] = src; mem[a/4+2] = dst; mem[a/4+3] = cmd;
  endtask

  task automatic set_next(input logic [31:0] a);
    @(negedge clk); cfg_next_we = 1'b1; cfg_next_wdata = a;
    @(negedge clk); cfg_next_we = 1'b0; #1;
  endtask

  task automatic set_run(input bit v);
    @(negedge clk); cfg_run_we = 1'b1; cfg_run_wdata = v;
    @(negedge clk); cfg_run_we = 1'b0; #1;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 5000 && !stopped_o; i++) tick(1);
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + 32'(i * 7 + 3);
    for (int i = 64; i < 128; i++) mem[i] = '0;
  endtask

  // {src, dst, len bytes, latency}
  localparam logic [63:0] VEC [0:3] = '{
    {16'h0000, 16'h0100, 16'd16, 16'd0},
    {16'h0040, 16'h0180, 16'd8,  16'd3},
    {16'h0010, 16'h0120, 16'd18, 16'd1},
    {16'h0080, 16'h01C0, 16'd4,  16'd2}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    tick(3);
    // R1 reset state (checked while rst is high and after release)
    check(stopped_o == 1'b1, "R1 stopped", 32'(stopped_o), 1);
    rst = 1'b0;
    tick(2);
    check(stopped_o == 1'b1, "R1 stopped", 32'(stopped_o), 1);
    check(run_o == 1'b0, "R1 run", 32'(run_o), 0);
    check(mem_req == 1'b0, "R1 req", 32'(mem_req), 0);

    // Vector table: single stop descriptor copies (R3, R4, R5)
    for (int v = 0; v < 4; v++) begin
      int s, d, l, nw;
      bit ok;
      s = int'(VEC[v][63:48]); d = int'(VEC[v][47:32]);
      l = int'(VEC[v][31:16]); nw = l / 4;
      fill_mem();
      put_desc(32'h300, 32'h0000_0301, 32'(s), 32'(d), 32'(l));
      lat = int'(VEC[v][15:0]);
      set_next(32'h300);
      n_log = 0;
      set_run(1'b1);
      wait_stop();
      check(n_log == 4 + 2 * nw, "R3 access count", 32'(n_log), 32'(4 + 2 * nw));
      ok = 1'b1;
      for (int k = 0; k < nw; k++) if (mem[d/4 + k] != mem[s/4 + k]) ok = 1'b0;
      check(ok, "R4 copied data", 32'(ok), 1);
      check(mem[d/4 + nw] == 0, "R4 word past end untouched", mem[d/4 + nw], 0);
      check(run_o == 1'b0, "R5 run cleared", 32'(run_o), 0);
    end

    // R2 / R7: zero-length stop descriptor, fetch order and start timing
    lat = 0;
    put_desc(32'h340, 32'h0000_0341, 0, 0, 0);
    set_next(32'h340);
    n_log = 0;
    set_run(1'b1);
    check(stopped_o == 1'b0, "R2 stop-state cleared", 32'(stopped_o), 0);
    wait_stop();
    check(n_log == 4, "R7 zero length no data", 32'(n_log), 4);
    for (int k = 0; k < 4; k++) begin
      check(log_addr[k] == 32'(32'h340 + 4 * k) && !log_we[k], "R2 fetch order", log_addr[k], 32'(32'h340 + 4 * k));
    end

    // R6: two-descriptor chain with noisy low link bits
    fill_mem();
    put_desc(32'h300, 32'h0000_0326, 32'h000, 32'h100, 8);
    put_desc(32'h320, 32'h0000_0001, 32'h040, 32'h140, 4);
    set_next(32'h300);
    n_log = 0;
    set_run(1'b1);
    wait_stop();
    check(n_log == 14, "R6 chain access count", 32'(n_log), 14);
    check(log_addr[8] == 32'h320, "R6 link masked", log_addr[8], 32'h320);
    check(mem[32'h140/4] == mem[32'h040/4], "R6 second copy", mem[32'h140/4], mem[32'h040/4]);
    tick(30);
    check(n_log == 14 && !mem_req, "R5 quiet after stop", 32'(n_log), 14);

    // R7: zero-length without stop follows link
    put_desc(32'h360, 32'h0000_0320, 0, 0, 0);
    set_next(32'h360);
    n_log = 0;
    set_run(1'b1);
    wait_stop();
    check(n_log == 10, "R7 zero length chained count", 32'(n_log), 10);
    check(log_addr[4] == 32'h320, "R7 direct to link", log_addr[4], 32'h320);

    // R8 / R9: pause mid-copy and resume
    begin
      int nk, npause;
      bit ok;
      fill_mem();
      lat = 2;
      put_desc(32'h380, 32'h0000_0381, 32'h000, 32'h100, 64);
      set_next(32'h380);
      n_log = 0;
      set_run(1'b1);
      for (int i = 0; i < 2000 && n_log < 9; i++) tick(1);
      set_run(1'b0);
      wait_stop();
      npause = n_log;
      nk = (npause - 4) / 2;
      check(stopped_o == 1'b1 && run_o == 1'b0, "R8 halted", 32'(stopped_o), 1);
      check(log_we[npause - 1] == 1'b1, "R8 last access is write", 32'(log_we[npause - 1]), 1);
      check(npause == 4 + 2 * nk && nk < 16, "R8 whole word moves", 32'(npause), 32'(4 + 2 * nk));
      check(mem[64 + nk] == 0, "R8 no write after pause", mem[64 + nk], 0);
      tick(40);
      check(n_log == npause, "R8 no request while paused", 32'(n_log), 32'(npause));
      set_run(1'b1);
      wait_stop();
      check(log_addr[npause] == 32'(4 * nk) && !log_we[npause], "R9 resume at source", log_addr[npause], 32'(4 * nk));
      check(n_log == 36, "R9 no refetch", 32'(n_log), 36);
      ok = 1'b1;
      for (int k = 0; k < 16; k++) if (mem[64 + k] != mem[k]) ok = 1'b0;
      check(ok, "R9 full copy after resume", 32'(ok), 1);
    end

    // R10: restart from a new link address
    lat = 1;
    set_next(32'h340);
    n_log = 0;
    set_run(1'b1);
    wait_stop();
    check(log_addr[0] == 32'h340 && n_log == 4, "R10 restart fetch", log_addr[0], 32'h340);

    finish_all();
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'(0), 32'(1));
    finish_all();
  end
endmodule